// File: doc/BRIEF.md
# Debug Access Status Monitor

This block sits beside the command engine of an on-chip debug port. It watches each memory or register access that a debug host starts and turns the outcome into sticky status flags. There are four flags: overrun, no-response, read-invalid and illegal-access. It also owns the bus request for the access. The request waits a bounded time for a free bus slot and is aborted when that time runs out.

Read data passes through the block to the host. When the current access failed or was illegal, every byte of that data is replaced by the filler value 0xEE. After an overrun the block blocks every internal access until the host resynchronises. Software clears three of the flags by writing ones to them. The overrun flag is cleared only by synchronisation.

A command is "busy" from the cycle it is accepted until the host signals completion after its access phase has ended. The host protocol, the bus and the CPU are outside the block and appear only as ports.

Top module: `dbg_access_monitor`

## Requirements
- R1: A `cmd_start_i` pulse that arrives while a command is busy sets `ovrun_o` on the next cycle. It drops the busy command and withdraws any pending bus request. The new command is not executed.
- R2: While `ovrun_o` is high, `suppress_o` is high and every `cmd_start_i` is ignored, so `bus_req_o` and `acc_fire_o` stay low. Only `sync_i` clears `ovrun_o`. `sync_i` also returns the block to idle and discards any command in the same cycle.
- R3: An access that waits TIMEOUT (default 512) consecutive request cycles without `free_slot_i` raises `abort_o` on the last of those cycles. That access is never performed. `noresp_o` is set and `bus_req_o` drops on the next cycle.
- R4: A legal command accepted while `stop_mode_i` is high and `clk_in_stop_i` is low sets `noresp_o` and raises no bus request. When `clk_in_stop_i` is high, the command requests the bus normally.
- R5: `rd_data_o` is 0xEE in every byte while `noresp_o` is high or while the current access was illegal. Otherwise it shows the data captured at the last performed read.
- R6: A read performed while `ecc_err_i` is high sets `rdinv_o`. The data actually read is still captured and returned.
- R7: A command with `unimpl_i`, `flash_wr_i` or `bad_reg_i` high at acceptance sets `illacc_o`. It never requests the bus and never starts the timeout, so it cannot also set `noresp_o`.
- R8: When `clr_i` is high, each bit of `clr_data_i` that is 1 clears its flag and each bit that is 0 has no effect. Bit 2 maps to no-response, bit 1 to read-invalid and bit 0 to illegal-access.
- R9: Reset clears all flags. When a set event and a clear (write-one or sync) fall in the same cycle, the flag ends up set.
- R10: `acc_fire_o` is high exactly when a request is pending, `free_slot_i` is high, and neither `cmd_start_i` nor `sync_i` is high. A `cmd_done_i` returns the block to idle only after the access phase has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Host command with internal access begins |
| cmd_rd_i | input | 1 | Command is a read (valid with `cmd_start_i`) |
| cmd_done_i | input | 1 | Host finished the command |
| sync_i | input | 1 | Host synchronisation event |
| free_slot_i | input | 1 | Bus has a free cycle this clock |
| stop_mode_i | input | 1 | Device is in stop mode |
| clk_in_stop_i | input | 1 | Debug clock kept running in stop mode |
| ecc_err_i | input | 1 | ECC error on the read data this cycle |
| unimpl_i | input | 1 | Address decodes to unimplemented memory |
| flash_wr_i | input | 1 | Access is a write to the flash array |
| bad_reg_i | input | 1 | Register number is invalid |
| rd_data_i | input | DATA_W | Data returned by the bus |
| clr_i | input | 1 | Status write strobe |
| clr_data_i | input | 3 | Write-one-to-clear bits {noresp, rdinv, illacc} |
| bus_req_o | output | 1 | Access waiting for a free slot |
| acc_fire_o | output | 1 | Access performed this cycle |
| abort_o | output | 1 | Pending access aborted on timeout |
| suppress_o | output | 1 | Internal accesses blocked |
| ovrun_o | output | 1 | Overrun flag |
| noresp_o | output | 1 | No-response flag |
| rdinv_o | output | 1 | Read-invalid flag |
| illacc_o | output | 1 | Illegal-access flag |
| rd_data_o | output | DATA_W | Read data to host, filler on error |

## Verification
Some rules are checked on every cycle. A request that overlaps a new command must end in overrun. Overrun must gate the bus request off and must persist until sync. An abort must fall exactly on the last cycle of the timeout window and be followed by no-response, and a counter in the checker tracks that window. The filler must appear whenever no-response is set, and read-invalid must hold unless its clear bit is written. The bench's scenarios are needed for the rest: the stop-mode rule, the per-access filler after an illegal command, data kept despite an ECC error, writes of zero having no effect, and the set-over-clear races. They are also needed for the boundary where a free slot arrives on the very last cycle of the window.

// File: rtl/dbg_stat_pkg.sv
package dbg_stat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } acc_state_e;

  localparam int unsigned NUM_W1C = 3;
  localparam int unsigned IDX_IL  = 0;
  localparam int unsigned IDX_RI  = 1;
  localparam int unsigned IDX_NR  = 2;

  localparam logic [7:0] FILLER_BYTE = 8'hEE;
endpackage

// File: rtl/dbg_slot_timer.sv
module dbg_slot_timer #(
  parameter int unsigned TIMEOUT = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
    end else if (run_i && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = (cnt_q == LAST);
endmodule

// File: rtl/dbg_w1c_flags.sv
module dbg_w1c_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  input  logic [N-1:0] clr_data_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= 1'b0;
      end else if (set_i[g]) begin
        q <= 1'b1;  // set beats clear
      end else if (clr_i && clr_data_i[g]) begin
        q <= 1'b0;
      end
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
  import dbg_stat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_start_i,
  input  logic cmd_rd_i,
  input  logic cmd_done_i,
  input  logic sync_i,
  input  logic free_slot_i,
  input  logic stop_mode_i,
  input  logic clk_in_stop_i,
  input  logic illegal_i,
  input  logic expire_i,
  output logic start_ok_o,
  output logic wait_run_o,
  output logic bus_req_o,
  output logic fire_o,
  output logic abort_o,
  output logic stop_block_o,
  output logic ovrun_o,
  output logic rd_q_o,
  output logic acc_ill_o
);
  acc_state_e st_q, st_d;
  logic ovrun_q, rd_q, acc_ill_q;
  logic busy, new_ovrun, blocked;

  assign busy       = (st_q != ST_IDLE);
  assign new_ovrun  = cmd_start_i && busy;
  assign start_ok_o = cmd_start_i && !busy && !ovrun_q && !sync_i;
  assign stop_block_o = stop_mode_i && !clk_in_stop_i;
  assign blocked    = illegal_i || stop_block_o;

  assign bus_req_o  = (st_q == ST_WAIT);
  assign fire_o     = bus_req_o && free_slot_i && !cmd_start_i && !sync_i;
  assign wait_run_o = bus_req_o && !free_slot_i && !cmd_start_i && !sync_i;
  assign abort_o    = wait_run_o && expire_i;

  always_comb begin
    st_d = st_q;
    if (sync_i || new_ovrun) begin
      st_d = ST_IDLE;
    end else if (start_ok_o) begin
      st_d = blocked ? ST_DONE : ST_WAIT;
    end else begin
      unique case (st_q)
        ST_WAIT: if (fire_o || abort_o) st_d = ST_DONE;
        ST_DONE: if (cmd_done_i)        st_d = ST_IDLE;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ovrun_q   <= 1'b0;
      rd_q      <= 1'b0;
      acc_ill_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ovrun_q <= new_ovrun || (ovrun_q && !sync_i);
      if (start_ok_o) begin
        rd_q      <= cmd_rd_i;
        acc_ill_q <= illegal_i;
      end
    end
  end

  assign ovrun_o   = ovrun_q;
  assign rd_q_o    = rd_q;
  assign acc_ill_o = acc_ill_q;
endmodule

// File: rtl/dbg_rdata_sel.sv
module dbg_rdata_sel
  import dbg_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] fill_word;

  for (genvar b = 0; b < NBYTES; b++) begin : g_fill
    assign fill_word[b*8 +: 8] = FILLER_BYTE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (capture_i) begin
      data_q <= rd_data_i;
    end
  end

  assign rd_data_o = fill_i ? fill_word : data_q;
endmodule

// File: rtl/dbg_access_monitor.sv
module dbg_access_monitor
  import dbg_stat_pkg::*;
#(
  parameter int unsigned TIMEOUT = 512,
  parameter int unsigned DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic              cmd_rd_i,
  input  logic              cmd_done_i,
  input  logic              sync_i,
  input  logic              free_slot_i,
  input  logic              stop_mode_i,
  input  logic              clk_in_stop_i,
  input  logic              ecc_err_i,
  input  logic              unimpl_i,
  input  logic              flash_wr_i,
  input  logic              bad_reg_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              clr_i,
  input  logic [2:0]        clr_data_i,
  output logic              bus_req_o,
  output logic              acc_fire_o,
  output logic              abort_o,
  output logic              suppress_o,
  output logic              ovrun_o,
  output logic              noresp_o,
  output logic              rdinv_o,
  output logic              illacc_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic illegal, start_ok, wait_run, expire, stop_block;
  logic rd_q, acc_ill, fire, abort;
  logic [NUM_W1C-1:0] set_vec, flags;

  assign illegal = unimpl_i || flash_wr_i || bad_reg_i;

  dbg_cmd_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_start_i  (cmd_start_i),
    .cmd_rd_i     (cmd_rd_i),
    .cmd_done_i   (cmd_done_i),
    .sync_i       (sync_i),
    .free_slot_i  (free_slot_i),
    .stop_mode_i  (stop_mode_i),
    .clk_in_stop_i(clk_in_stop_i),
    .illegal_i    (illegal),
    .expire_i     (expire),
    .start_ok_o   (start_ok),
    .wait_run_o   (wait_run),
    .bus_req_o    (bus_req_o),
    .fire_o       (fire),
    .abort_o      (abort),
    .stop_block_o (stop_block),
    .ovrun_o      (ovrun_o),
    .rd_q_o       (rd_q),
    .acc_ill_o    (acc_ill)
  );

  dbg_slot_timer #(.TIMEOUT(TIMEOUT)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_ok),
    .run_i   (wait_run),
    .expire_o(expire)
  );

  assign set_vec[IDX_NR] = abort || (start_ok && !illegal && stop_block);
  assign set_vec[IDX_RI] = fire && rd_q && ecc_err_i;
  assign set_vec[IDX_IL] = start_ok && illegal;

  dbg_w1c_flags #(.N(NUM_W1C)) i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .clr_i     (clr_i),
    .clr_data_i(clr_data_i),
    .flag_o    (flags)
  );

  dbg_rdata_sel #(.DATA_W(DATA_W)) i_rdata (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(fire && rd_q),
    .rd_data_i(rd_data_i),
    .fill_i   (flags[IDX_NR] || acc_ill),
    .rd_data_o(rd_data_o)
  );

  assign acc_fire_o = fire;
  assign abort_o    = abort;
  assign suppress_o = ovrun_o;
  assign noresp_o   = flags[IDX_NR];
  assign rdinv_o    = flags[IDX_RI];
  assign illacc_o   = flags[IDX_IL];
endmodule

// File: rtl/dbg_access_monitor_chk.sv
module dbg_access_monitor_chk #(
  parameter int unsigned TIMEOUT = 512,
  parameter int unsigned DATA_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_start_i,
  input logic              sync_i,
  input logic              free_slot_i,
  input logic              clr_i,
  input logic [2:0]        clr_data_i,
  input logic              bus_req_o,
  input logic              acc_fire_o,
  input logic              abort_o,
  input logic              suppress_o,
  input logic              ovrun_o,
  input logic              noresp_o,
  input logic              rdinv_o,
  input logic              illacc_o,
  input logic [DATA_W-1:0] rd_data_o
);
  localparam logic [DATA_W-1:0] FILL = {(DATA_W/8){8'hEE}};
  int unsigned wait_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_cnt <= 0;
    else if (bus_req_o && !free_slot_i && !cmd_start_i && !sync_i && !abort_o)
      wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
  end

  AST_OVRUN_ON_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && cmd_start_i |=> ovrun_o);  // R1
  AST_SUPPRESS_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suppress_o |-> !bus_req_o && !acc_fire_o);  // R2
  AST_OVRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovrun_o && !sync_i |=> ovrun_o);  // R2
  AST_ABORT_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> wait_cnt == TIMEOUT - 1);  // R3
  AST_ABORT_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !free_slot_i && !cmd_start_i && !sync_i && wait_cnt == TIMEOUT - 1
    |-> abort_o);  // R3
  AST_ABORT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> noresp_o && !bus_req_o);  // R3
  AST_FILLER_ON_NR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noresp_o |-> rd_data_o == FILL);  // R5
  AST_ILL_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(illacc_o) |-> !bus_req_o);  // R7
  AST_RI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdinv_o && !(clr_i && clr_data_i[1]) |=> rdinv_o);  // R8
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o && clr_i && clr_data_i[2] |=> noresp_o);  // R9
  AST_FIRE_NEEDS_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_fire_o |-> free_slot_i && bus_req_o && !abort_o);  // R10
endmodule

bind dbg_access_monitor dbg_access_monitor_chk #(.TIMEOUT(TIMEOUT), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_dbg_access_monitor.sv
`timescale 1ns/1ps
module test_dbg_access_monitor;
  localparam int TMO = 512;
  localparam int DW  = 16;
  localparam logic [DW-1:0] FILL = 16'hEEEE;

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, cmd_rd = 0, cmd_done = 0, sync = 0, free = 0;
  logic stop = 0, cis = 0, ecc = 0, unimpl = 0, flwr = 0, badreg = 0;
  logic [DW-1:0] rdi = '0;
  logic clr = 0;
  logic [2:0] cd = '0;
  logic bus_req, fire, abort, supp, ov, nr, ri, il;
  logic [DW-1:0] rdo;

  int n_tests = 0, n_fail = 0, cycles = 0;

  always #2 clk = ~clk;

  dbg_access_monitor #(.TIMEOUT(TMO), .DATA_W(DW)) i_dbg_access_monitor (
    .clk_i(clk), .rst_ni(rst_n), .cmd_start_i(cmd_start), .cmd_rd_i(cmd_rd),
    .cmd_done_i(cmd_done), .sync_i(sync), .free_slot_i(free), .stop_mode_i(stop),
    .clk_in_stop_i(cis), .ecc_err_i(ecc), .unimpl_i(unimpl), .flash_wr_i(flwr),
    .bad_reg_i(badreg), .rd_data_i(rdi), .clr_i(clr), .clr_data_i(cd),
    .bus_req_o(bus_req), .acc_fire_o(fire), .abort_o(abort), .suppress_o(supp),
    .ovrun_o(ov), .noresp_o(nr), .rdinv_o(ri), .illacc_o(il), .rd_data_o(rdo));

  // behavioural reference: 0 idle, 1 waiting, 2 access over
  int m_st = 0, m_cnt = 0;
  bit m_ov, m_nr, m_ri, m_il, m_rd, m_ai;
  logic [DW-1:0] m_data = '0;

  function automatic bit m_busy(); return m_st != 0; endfunction
  function automatic bit m_fire(); return m_st == 1 && free && !cmd_start && !sync; endfunction
  function automatic bit m_abort();
    return m_st == 1 && !free && !cmd_start && !sync && m_cnt == TMO - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_ov <= 0; m_nr <= 0; m_ri <= 0; m_il <= 0;
      m_rd <= 0; m_ai <= 0; m_data <= '0;
    end else begin
      bit ok, ill, blk, f, a;
      ok  = cmd_start && !m_busy() && !m_ov && !sync;
      ill = unimpl || flwr || badreg;
      blk = stop && !cis;
      f = m_fire(); a = m_abort();
      m_ov <= (cmd_start && m_busy()) || (m_ov && !sync);
      m_nr <= a || (ok && !ill && blk) || (m_nr && !(clr && cd[2]));
      m_ri <= (f && m_rd && ecc) || (m_ri && !(clr && cd[1]));
      m_il <= (ok && ill) || (m_il && !(clr && cd[0]));
      if (f && m_rd) m_data <= rdi;
      if (ok) begin m_rd <= cmd_rd; m_ai <= ill; m_cnt <= 0; end
      if (sync || (cmd_start && m_busy())) m_st <= 0;
      else if (ok) m_st <= (ill || blk) ? 2 : 1;
      else if (m_st == 1) begin
        if (f || a) m_st <= 2; else m_cnt <= m_cnt + 1;
      end else if (m_st == 2 && cmd_done) m_st <= 0;
    end
  end

  task automatic chk(input bit good, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(bus_req == (m_st == 1), "R10 bus_req", bus_req, m_st == 1);
      chk(fire == m_fire(), "R10 acc_fire", fire, m_fire());
      chk(abort == m_abort(), "R3 abort", abort, m_abort());
      chk(ov == m_ov && supp == m_ov, "R1 R2 overrun/suppress", {ov, supp}, {m_ov, m_ov});
      chk(nr == m_nr, "R3 R4 noresp", nr, m_nr);
      chk(ri == m_ri, "R6 rdinv", ri, m_ri);
      chk(il == m_il, "R7 illacc", il, m_il);
      chk(rdo == ((m_nr || m_ai) ? FILL : m_data), "R5 rd_data", rdo,
          (m_nr || m_ai) ? FILL : m_data);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic start_cmd(input bit rd, input bit u = 0, input bit fw = 0, input bit br = 0);
    cmd_start = 1; cmd_rd = rd; unimpl = u; flwr = fw; badreg = br;
    tick();
    cmd_start = 0; cmd_rd = 0; unimpl = 0; flwr = 0; badreg = 0;
  endtask

  task automatic finish_cmd();
    cmd_done = 1; tick(); cmd_done = 0;
  endtask

  task automatic wclr(input logic [2:0] v);
    clr = 1; cd = v; tick(); clr = 0; cd = '0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    tick(3);
    // R9 reset state
    chk({ov, nr, ri, il, bus_req} == 5'b0, "R9 reset flags", {ov, nr, ri, il, bus_req}, 0);
    rst_n = 1; tick();

    // R10 legal read after three busy bus cycles
    start_cmd(1); tick(3);
    chk(bus_req == 1, "R10 waiting", bus_req, 1);
    free = 1; rdi = 16'h5AA5; #0;
    chk(fire == 1, "R10 fire", fire, 1);
    tick(); free = 0;
    chk(rdo == 16'h5AA5 && !bus_req, "R10 read data", rdo, 16'h5AA5);
    finish_cmd();

    // R6 ECC error keeps real data
    start_cmd(1); free = 1; ecc = 1; rdi = 16'h1234; tick(); free = 0; ecc = 0;
    chk(ri == 1 && rdo == 16'h1234, "R6 rdinv with real data", {ri, rdo}, {1'b1, 16'h1234});
    finish_cmd();

    // R8 write zero then one
    wclr(3'b101);
    chk(ri == 1, "R8 write-0 no effect", ri, 1);
    wclr(3'b010);
    chk(ri == 0, "R8 write-1 clears", ri, 0);

    // R7 illegal decodes
    start_cmd(1, 1, 0, 0);
    chk(il == 1 && !bus_req && rdo == FILL, "R7 unimpl", {il, bus_req}, 2'b10);
    finish_cmd(); wclr(3'b001);
    start_cmd(0, 0, 1, 0);
    chk(il == 1 && !bus_req, "R7 flash write", il, 1);
    finish_cmd(); wclr(3'b001);
    start_cmd(1, 0, 0, 1);
    chk(il == 1 && rdo == FILL, "R5 illegal filler", rdo, FILL);
    finish_cmd();
    start_cmd(1); free = 1; rdi = 16'h0F0F; tick(); free = 0;
    chk(rdo == 16'h0F0F && nr == 0, "R5 filler per access", rdo, 16'h0F0F);
    finish_cmd(); wclr(3'b001);

    // R4 stop mode
    stop = 1; cis = 1;
    start_cmd(1);
    chk(bus_req == 1 && nr == 0, "R4 clock kept in stop", bus_req, 1);
    free = 1; tick(); free = 0; finish_cmd();
    cis = 0;
    start_cmd(1);
    chk(nr == 1 && !bus_req && rdo == FILL, "R4 stop blocks access", {nr, bus_req}, 2'b10);
    stop = 0; finish_cmd(); wclr(3'b100);
    chk(nr == 0, "R8 noresp clears", nr, 0);

    // R3 timeout, with R9 same-cycle clear
    start_cmd(1); tick(TMO - 2);
    chk(abort == 0, "R3 no early abort", abort, 0);
    tick();
    chk(abort == 1, "R3 abort at limit", abort, 1);
    clr = 1; cd = 3'b100; tick(); clr = 0; cd = '0;
    chk(nr == 1 && !bus_req, "R9 set beats clear", nr, 1);
    finish_cmd(); wclr(3'b100);

    // R3 boundary: slot on last cycle
    start_cmd(1); tick(TMO - 1);
    free = 1; rdi = 16'hBEEF; #0;
    chk(abort == 0 && fire == 1, "R3 slot on last cycle", {abort, fire}, 2'b01);
    tick(); free = 0;
    chk(nr == 0 && rdo == 16'hBEEF, "R3 no timeout", nr, 0);
    finish_cmd();

    // R1 R2 overrun and suppression
    start_cmd(1); tick(2);
    start_cmd(1);
    chk(ov == 1 && supp == 1 && !bus_req, "R1 overrun", {ov, bus_req}, 2'b10);
    start_cmd(1); tick(2);
    chk(bus_req == 0 && ov == 1, "R2 start suppressed", bus_req, 0);
    wclr(3'b111);
    chk(ov == 1, "R2 write does not clear overrun", ov, 1);
    sync = 1; tick(); sync = 0;
    chk(ov == 0 && supp == 0, "R2 sync clears", ov, 0);
    start_cmd(1);
    chk(bus_req == 1, "R2 access after sync", bus_req, 1);
    // R9 overrun set with sync same cycle
    cmd_start = 1; sync = 1; tick(); cmd_start = 0; sync = 0;
    chk(ov == 1, "R9 overrun beats sync", ov, 1);
    sync = 1; tick(); sync = 0;
    chk(ov == 0, "R2 final sync", ov, 0);

    tick(4);
    summary();
  end
endmodule